// File: doc/BRIEF.md
# Digit-Serial GF(3^97) Multiplier

This block multiplies two elements of the ternary extension field GF(3^97). Each element is a polynomial of degree at most 96 with coefficients in GF(3). On each port it is packed as a 194-bit vector with two bits per coefficient: coefficient i occupies bits [2i+1:2i]. A zero coefficient may be written as 00 or 01, a one as 10 and a two as 11. Only the high bit separates zero from non-zero.

A job is handed over with a valid/ready handshake on the operand side. The unit then walks operand A from its highest coefficient down, DIGIT coefficients per clock. In each step it shifts a running accumulator up by one power of x, folds the overflow back with x^97 = 1 − x^16, and adds the current A coefficient times B. After ceil(97/DIGIT) clocks the reduced product is offered on the result side through a second valid/ready pair.

The result stays valid, and its value does not change, until the consumer takes it. While a job is running or its result is waiting, the operand side deasserts ready. Back-pressure therefore stalls the producer and never drops a product. To square an element, present it on both operand inputs.

Top module: `tmul_gf3_digit_mul`

## Requirements
- R1: An input coefficient coded 01 is treated exactly like 00 (zero), 10 as one and 11 as two; coefficient i sits at bits [2i+1:2i] of every 194-bit vector.
- R2: Every coefficient of the product uses only the codes 00, 10 or 11; a zero product coefficient is always 00, never 01.
- R3: The product equals A·B reduced modulo x^97 + x^16 − 1, with all coefficient arithmetic modulo 3, for arbitrary operands including zero, one and the element whose coefficients are all two.
- R4: The reduction folds x^97 into 1 + 2·x^16, so x^96 times x gives coefficient 0 equal to 10, coefficient 16 equal to 11 and every other coefficient 00.
- R5: out_valid rises exactly ceil(97/DIGIT) clock edges after the edge on which in_valid and in_ready were both high (25 edges for DIGIT = 4).
- R6: in_ready is low from the accepting edge until the result has been taken; in_valid and operand changes during that time start no job and do not alter the product.
- R7: While out_valid is high and out_ready is low, out_valid stays high and product holds its value; on an edge with both high, out_valid falls and in_ready rises.
- R8: After reset, in_ready is high and out_valid is low.
- R9: Presenting the same element on op_a and op_b yields its square.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on op_a/op_b are offered |
| in_ready | output | 1 | Unit idle; an offered job is accepted on this edge |
| op_a | input | 194 | Multiplier operand, consumed highest coefficient first |
| op_b | input | 194 | Multiplicand operand |
| out_valid | output | 1 | product holds a finished result |
| out_ready | input | 1 | Consumer takes the result on this edge |
| product | output | 194 | Reduced product, canonical coefficient codes |

## Verification
The assertions assume that every input is driven to a known 0 or 1 on each edge. They also assume that rst_n is held low long enough for the first edge to see the idle state, and they place no constraint on when out_ready or in_valid toggle. The stimulus drives all inputs at the falling edge from defined values. It holds out_ready low for several cycles while a result is pending, and it raises in_valid with fresh operands both during the computation and during that hold. Operand patterns include the 01 zero code, single-term polynomials that force the reduction fold, and dense random elements.

// File: rtl/tmul_pkg.sv
package tmul_pkg;

  localparam int FIELD_M = 97;
  localparam int TAP_K   = 16;

  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_ZERO = 2'b00;
  localparam trit_t TRIT_ONE  = 2'b10;
  localparam trit_t TRIT_TWO  = 2'b11;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_HOLD = 2'd2
  } tmul_state_e;

  // Numeric value 0..2 of a coded coefficient; high bit low means zero.
  function automatic logic [1:0] trit_val(trit_t c);
    if (!c[1]) return 2'd0;
    return c[0] ? 2'd2 : 2'd1;
  endfunction

  function automatic trit_t trit_code(logic [1:0] v);
    case (v)
      2'd1:    return TRIT_ONE;
      2'd2:    return TRIT_TWO;
      default: return TRIT_ZERO;
    endcase
  endfunction

  function automatic trit_t trit_add(trit_t x, trit_t y);
    logic [2:0] s;
    s = {1'b0, trit_val(x)} + {1'b0, trit_val(y)};
    if (s >= 3'd3) s = s - 3'd3;
    return trit_code(s[1:0]);
  endfunction

  function automatic trit_t trit_neg(trit_t x);
    if (!x[1]) return TRIT_ZERO;
    return {1'b1, ~x[0]};
  endfunction

  function automatic trit_t trit_sub(trit_t x, trit_t y);
    return trit_add(x, trit_neg(y));
  endfunction

  // 1*1=1, 1*2=2, 2*2=1: sign bits combine by xor.
  function automatic trit_t trit_mul(trit_t x, trit_t y);
    if (!x[1] || !y[1]) return TRIT_ZERO;
    return {1'b1, x[0] ^ y[0]};
  endfunction

endpackage

// File: rtl/tmul_step.sv
// One Horner step: acc_o = (acc_i * x mod P) + a_coef_i * b_i
// with P = x^M + x^K - 1, so the coefficient leaving the top
// re-enters at x^0 with sign + and at x^K with sign -.
module tmul_step
  import tmul_pkg::*;
#(
  parameter int M = FIELD_M,
  parameter int K = TAP_K
) (
  input  logic [2*M-1:0] acc_i,
  input  logic [2*M-1:0] b_i,
  input  logic [1:0]     a_coef_i,
  output logic [2*M-1:0] acc_o
);

  trit_t top;
  assign top = acc_i[2*M-1 -: 2];

  for (genvar i = 0; i < M; i++) begin : g_coef
    trit_t moved;
    if (i == 0) begin : g_wrap
      assign moved = top;
    end else if (i == K) begin : g_tap
      assign moved = trit_sub(acc_i[2*i-2 +: 2], top);
    end else begin : g_shift
      assign moved = acc_i[2*i-2 +: 2];
    end
    assign acc_o[2*i +: 2] = trit_add(moved, trit_mul(a_coef_i, b_i[2*i +: 2]));
  end

endmodule

// File: rtl/tmul_digit.sv
// Chains DIGIT Horner steps; the most significant coefficient of the
// digit is applied first.
module tmul_digit
  import tmul_pkg::*;
#(
  parameter int M     = FIELD_M,
  parameter int K     = TAP_K,
  parameter int DIGIT = 4
) (
  input  logic [2*M-1:0]     acc_i,
  input  logic [2*M-1:0]     b_i,
  input  logic [2*DIGIT-1:0] digit_i,
  output logic [2*M-1:0]     acc_o
);

  logic [2*M-1:0] chain [DIGIT+1];

  assign chain[0] = acc_i;

  for (genvar j = 0; j < DIGIT; j++) begin : g_step
    tmul_step #(.M(M), .K(K)) u_step (
      .acc_i   (chain[j]),
      .b_i     (b_i),
      .a_coef_i(digit_i[2*(DIGIT-1-j) +: 2]),
      .acc_o   (chain[j+1])
    );
  end

  assign acc_o = chain[DIGIT];

endmodule

// File: rtl/tmul_ctrl.sv
// Job sequencer: idle -> run for STEPS cycles -> hold result until taken.
module tmul_ctrl
  import tmul_pkg::*;
#(
  parameter int STEPS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic load_o,
  output logic run_o
);

  localparam int CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  tmul_state_e    st_q, st_d;
  logic [CW-1:0]  cnt_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (in_valid)       st_d = S_RUN;
      S_RUN:   if (cnt_q == LAST)  st_d = S_HOLD;
      S_HOLD:  if (out_ready)      st_d = S_IDLE;
      default:                     st_d = S_IDLE;
    endcase
  end

  assign in_ready  = (st_q == S_IDLE);
  assign out_valid = (st_q == S_HOLD);
  assign run_o     = (st_q == S_RUN);
  assign load_o    = in_ready && in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (load_o)     cnt_q <= '0;
      else if (run_o) cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/tmul_gf3_digit_mul.sv
module tmul_gf3_digit_mul
  import tmul_pkg::*;
#(
  parameter int M     = FIELD_M,
  parameter int K     = TAP_K,
  parameter int DIGIT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [2*M-1:0] op_a,
  input  logic [2*M-1:0] op_b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*M-1:0] product
);

  localparam int STEPS = (M + DIGIT - 1) / DIGIT;
  localparam int PADC  = STEPS * DIGIT;
  localparam int PADW  = 2 * PADC;

  logic             load, run;
  logic [PADW-1:0]  a_sh_q;
  logic [2*M-1:0]   b_q;
  logic [2*M-1:0]   acc_q;
  logic [2*M-1:0]   acc_nx;

  tmul_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .load_o   (load),
    .run_o    (run)
  );

  tmul_digit #(.M(M), .K(K), .DIGIT(DIGIT)) u_digit (
    .acc_i  (acc_q),
    .b_i    (b_q),
    .digit_i(a_sh_q[PADW-1 -: 2*DIGIT]),
    .acc_o  (acc_nx)
  );

  // Operand A is zero-extended at the top so the padded leading
  // coefficients are consumed first and contribute nothing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sh_q <= '0;
      b_q    <= '0;
      acc_q  <= '0;
    end else if (load) begin
      a_sh_q <= PADW'(op_a);
      b_q    <= op_b;
      acc_q  <= '0;
    end else if (run) begin
      a_sh_q <= a_sh_q << (2 * DIGIT);
      acc_q  <= acc_nx;
    end
  end

  assign product = acc_q;

endmodule

// File: rtl/tmul_gf3_digit_mul_chk.sv
module tmul_gf3_digit_mul_chk #(
  parameter int M     = 97,
  parameter int STEPS = 25
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*M-1:0] product
);

  localparam int CW = $clog2(STEPS + 2);
  localparam logic [CW-1:0] LAT_CAP  = CW'(STEPS + 1);
  localparam logic [CW-1:0] LAT_WANT = CW'(STEPS);

  logic [CW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     lat_q <= '0;
    else if (in_valid && in_ready)  lat_q <= '0;
    else if (!out_valid && lat_q != LAT_CAP) lat_q <= lat_q + 1'b1;
  end

  function automatic logic has_alt_zero(logic [2*M-1:0] v);
    for (int i = 0; i < M; i++)
      if (v[2*i +: 2] == 2'b01) return 1'b1;
    return 1'b0;
  endfunction

  a_r8_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (in_ready && !out_valid));

  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_q == LAT_WANT));

  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !out_valid));

  a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(product)));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  a_r2_canonical_out: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !has_alt_zero(product));

endmodule

bind tmul_gf3_digit_mul tmul_gf3_digit_mul_chk #(.M(M), .STEPS(STEPS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .product  (product)
);

// File: tb/tmul_gf3_digit_mul_tb.sv
`timescale 1ns/1ps
module tmul_gf3_digit_mul_tb_top;

  localparam int M     = 97;
  localparam int DIGIT = 4;
  localparam int STEPS = (M + DIGIT - 1) / DIGIT;
  localparam int W     = 2 * M;

  // kind codes: 0 zero(00), 1 zero(01 everywhere), 2 one, 3 all twos,
  // 4 random, 6 x^96, 7 x, 8 (B only) same as A
  localparam int NVEC = 12;
  localparam logic [23:0] VEC [NVEC] = '{
    {4'd0, 4'd4, 16'h1234},
    {4'd4, 4'd1, 16'h0F0F},
    {4'd2, 4'd4, 16'hBEEF},
    {4'd4, 4'd2, 16'h5A5A},
    {4'd3, 4'd3, 16'h0001},
    {4'd3, 4'd4, 16'h7777},
    {4'd4, 4'd4, 16'hC0DE},
    {4'd4, 4'd4, 16'h9E37},
    {4'd4, 4'd4, 16'h4242},
    {4'd6, 4'd7, 16'h0002},
    {4'd7, 4'd6, 16'h0003},
    {4'd4, 4'd8, 16'hFACE}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] product;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  tmul_gf3_digit_mul #(.DIGIT(DIGIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_ready(out_ready),
    .product(product)
  );

  function automatic int tval(logic [1:0] c);
    if (!c[1]) return 0;
    return c[0] ? 2 : 1;
  endfunction

  function automatic logic [1:0] tenc(int v);
    if (v == 1) return 2'b10;
    if (v == 2) return 2'b11;
    return 2'b00;
  endfunction

  // Schoolbook product, then fold degrees 192..97 using
  // x^k = x^(k-97) - x^(k-81).
  function automatic logic [W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
    int p [2*M-1];
    logic [W-1:0] r;
    int c;
    for (int k = 0; k < 2*M-1; k++) p[k] = 0;
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++)
        p[i+j] += tval(a[2*i +: 2]) * tval(b[2*j +: 2]);
    for (int k = 2*M-2; k >= M; k--) begin
      c = p[k] % 3;
      p[k] = 0;
      p[k-97] += c;
      p[k-81] += 2 * c;
    end
    r = '0;
    for (int i = 0; i < M; i++) r[2*i +: 2] = tenc(p[i] % 3);
    return r;
  endfunction

  function automatic logic [W-1:0] canon(logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < M; i++) r[2*i +: 2] = v[2*i+1] ? v[2*i +: 2] : 2'b00;
    return r;
  endfunction

  function automatic bit any_alt_zero(logic [W-1:0] v);
    for (int i = 0; i < M; i++) if (v[2*i +: 2] == 2'b01) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [W-1:0] make_op(int kind, logic [15:0] seed);
    logic [31:0]  s;
    logic [W-1:0] v;
    s = {16'hACE1, seed} | 32'd1;
    v = '0;
    case (kind)
      1: for (int i = 0; i < M; i++) v[2*i +: 2] = 2'b01;
      2: v[1:0] = 2'b10;
      3: for (int i = 0; i < M; i++) v[2*i +: 2] = 2'b11;
      4: for (int i = 0; i < M; i++) begin
           s ^= s << 13; s ^= s >> 17; s ^= s << 5;
           v[2*i +: 2] = s[9:8];
         end
      6: v[W-1 -: 2] = 2'b10;
      7: v[3:2] = 2'b10;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_job(input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [W-1:0] res, output int lat);
    @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!out_valid && lat < 1000);
    res = product;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b, exp, res, first;
    int lat;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: idle after reset
    check(in_ready && !out_valid, "R8 reset state", W'({in_ready, out_valid}), W'(2'b10));

    // Table walk: R3 generic, R9 squares, R5 latency, R2 canonical codes
    for (int v = 0; v < NVEC; v++) begin
      a = make_op(int'(VEC[v][23:20]), VEC[v][15:0]);
      if (VEC[v][19:16] == 4'd8) b = a;
      else b = make_op(int'(VEC[v][19:16]), VEC[v][15:0] ^ 16'h3C3C);
      exp = ref_mul(a, b);
      run_job(a, b, res, lat);
      check(res == exp, (VEC[v][19:16] == 4'd8) ? "R9 square" : "R3 product", res, exp);
      check(lat == STEPS, "R5 latency", W'(lat), W'(STEPS));
      check(!any_alt_zero(res), "R2 canonical zero", res, canon(res));
    end

    // R4: x^96 * x folds to 1 + 2 x^16
    exp = '0; exp[1:0] = 2'b10; exp[33:32] = 2'b11;
    run_job(make_op(6, 0), make_op(7, 0), res, lat);
    check(res == exp, "R4 fold", res, exp);

    // R1: zeros coded 01 behave as zero; one times B gives B canonicalized
    b = make_op(4, 16'h2468);
    run_job(make_op(1, 0), b, res, lat);
    check(res == '0, "R1 alt zero operand", res, '0);
    run_job(make_op(2, 0), b, res, lat);
    check(res == canon(b), "R1 one times B", res, canon(b));

    // R6/R7: traffic during computation and during hold
    a = make_op(4, 16'h1111);
    b = make_op(4, 16'h2222);
    first = ref_mul(a, b);
    @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_a = make_op(3, 0); op_b = make_op(4, 16'h9999);
    check(!in_ready, "R6 busy not ready", W'(in_ready), W'(0));
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 1000) begin
      @(negedge clk); lat++;
    end
    check(product == first, "R6 ignored while busy", product, first);
    in_valid = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid && product == first, "R7 hold under stall", product, first);
    check(!in_ready, "R6 not ready while holding", W'(in_ready), W'(0));
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R7 release", W'({in_ready, out_valid}), W'(2'b10));
    repeat (STEPS + 3) @(negedge clk);
    check(!out_valid && in_ready, "R6 no stray job", W'({in_ready, out_valid}), W'(2'b10));

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule